// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block tells a half-duplex Ethernet transmitter when it may begin a frame. It watches carrier activity on both the transmit and the receive side. While either side is active it holds off. Once the medium is quiet, it counts a programmable deferral in bit times and then raises a start-permitted grant. A control bit selects between two deferral styles. In the single-stage style, any activity before the grant starts the count again. In the two-stage style, only the first stage can be restarted by activity, and the second stage runs to its end whatever the medium does.

The deferral is built from two 8-bit stage lengths, counted in clock cycles with one cycle per bit time. After reset they hold 64 and 32, which gives a 96-bit-time total. A load strobe replaces both lengths at once. In full-duplex mode, activity is not looked at and only the gap count applies. Once the grant is raised it stays up until the transmitter pulses its frame-started input. That pulse clears the grant and begins a new deferral.

Top module: `hdx_defer_timer`

## Requirements
- R1: After reset the grant is low, and the stage lengths are 64 and 32, so the total deferral is 96 cycles.
- R2: In half-duplex single-stage mode, a cycle with tx_active_i or rx_active_i high and the grant low is followed by a cycle with the grant still low.
- R3: In single-stage mode with a frame pending and the medium quiet, the grant rises on the (total+1)-th rising edge after the last edge that restarted the count, where total is the sum of the two stage lengths.
- R4: In half-duplex single-stage mode, activity on any edge before the grant returns the count to zero.
- R5: In half-duplex two-stage mode, activity on an edge while the count is below the first stage length returns the count to zero.
- R6: In half-duplex two-stage mode, activity while the count is at or above the first stage length is ignored when a frame is pending, and the grant rises on the same edge as it would on a quiet medium.
- R7: In full-duplex mode (half_duplex_i low), activity is ignored, and the grant follows the deferral count alone.
- R8: Once the grant is high it stays high through any activity until tx_start_i is sampled high. That edge clears the grant and returns the count to zero.
- R9: cfg_load_i sampled high loads cfg_part1_i and cfg_part2_i as the new first and second stage lengths.
- R10: With frame_pending_i low the grant never rises. If a frame becomes pending after the count has completed, the grant rises on the next edge.
- R11: In half-duplex two-stage mode, when the count has completed and no frame is pending, activity returns the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex_i | input | 1 | 1 = half-duplex, 0 = full-duplex |
| two_part_i | input | 1 | 1 = two-stage deferral, 0 = single-stage |
| tx_active_i | input | 1 | Transmit-side carrier activity |
| rx_active_i | input | 1 | Receive-side carrier activity |
| frame_pending_i | input | 1 | A frame is waiting to be sent |
| tx_start_i | input | 1 | Transmitter has started the granted frame |
| cfg_load_i | input | 1 | Load strobe for both stage lengths |
| cfg_part1_i | input | 8 | New first stage length in bit times |
| cfg_part2_i | input | 8 | New second stage length in bit times |
| start_ok_o | output | 1 | Start-permitted grant |

## Verification
The hardest case to reach is the boundary between the two stages in two-stage mode. Activity has to arrive exactly when the count crosses the first stage length, and again when the count has completed with no frame pending. The bench reaches these points with short stage lengths loaded through the load strobe. It restarts the count with a frame-start pulse, waits a counted number of cycles, and only then raises activity, so each edge lands on a known count value. A behavioural model is compared with the grant on every cycle as well.

// File: rtl/hdx_defer_pkg.sv
package hdx_defer_pkg;
    localparam int GAP_W = 8;
    localparam int SUM_W = GAP_W + 1;

    typedef struct packed {
        logic [SUM_W-1:0] cnt;
        logic             grant;
        logic [GAP_W-1:0] p1;
        logic [GAP_W-1:0] p2;
    } defer_st_t;
endpackage

// File: rtl/hdx_medium_sense.sv
module hdx_medium_sense (
    input  logic half_duplex_i,
    input  logic tx_active_i,
    input  logic rx_active_i,
    output logic busy_o
);
    // Carrier only matters when the medium is shared.
    assign busy_o = half_duplex_i & (tx_active_i | rx_active_i);
endmodule

// File: rtl/hdx_gap_window.sv
module hdx_gap_window
    import hdx_defer_pkg::*;
(
    input  logic [SUM_W-1:0] cnt_i,
    input  logic [GAP_W-1:0] p1_i,
    input  logic [GAP_W-1:0] p2_i,
    output logic [SUM_W-1:0] total_o,
    output logic             done_o,
    output logic             first_o
);
    assign total_o = {1'b0, p1_i} + {1'b0, p2_i};
    assign done_o  = (cnt_i >= total_o);
    assign first_o = (cnt_i < {1'b0, p1_i});
endmodule

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer
    import hdx_defer_pkg::*;
#(
    parameter logic [GAP_W-1:0] PART1_RST = GAP_W'(64),
    parameter logic [GAP_W-1:0] PART2_RST = GAP_W'(32)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_duplex_i,
    input  logic             two_part_i,
    input  logic             tx_active_i,
    input  logic             rx_active_i,
    input  logic             frame_pending_i,
    input  logic             tx_start_i,
    input  logic             cfg_load_i,
    input  logic [GAP_W-1:0] cfg_part1_i,
    input  logic [GAP_W-1:0] cfg_part2_i,
    output logic             start_ok_o
);
    defer_st_t        st_d, st_q;
    logic             busy_w, done_w, first_w, elig_w, restart_w;
    logic [SUM_W-1:0] total_w, cnt_q;

    assign cnt_q = st_q.cnt;

    hdx_medium_sense u_sense (
        .half_duplex_i (half_duplex_i),
        .tx_active_i   (tx_active_i),
        .rx_active_i   (rx_active_i),
        .busy_o        (busy_w)
    );

    hdx_gap_window u_window (
        .cnt_i   (st_q.cnt),
        .p1_i    (st_q.p1),
        .p2_i    (st_q.p2),
        .total_o (total_w),
        .done_o  (done_w),
        .first_o (first_w)
    );

    // Two-stage: only the first stage, or an idle finished count, restarts.
    assign elig_w    = two_part_i ? (first_w | (done_w & ~frame_pending_i)) : 1'b1;
    assign restart_w = busy_w & elig_w & ~st_q.grant;

    always_comb begin
        st_d = st_q;
        if (cfg_load_i) begin
            st_d.p1 = cfg_part1_i;
            st_d.p2 = cfg_part2_i;
        end
        if (tx_start_i) begin
            st_d.cnt   = '0;
            st_d.grant = 1'b0;
        end else if (!st_q.grant) begin
            if (restart_w) begin
                st_d.cnt = '0;
            end else begin
                if (frame_pending_i && done_w) st_d.grant = 1'b1;
                if (!done_w) st_d.cnt = st_q.cnt + SUM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, grant: 1'b0, p1: PART1_RST, p2: PART2_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_ok_o = st_q.grant;
endmodule

// File: rtl/hdx_defer_checker.sv
module hdx_defer_checker
    import hdx_defer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             half,
    input logic             two,
    input logic             tx_act,
    input logic             rx_act,
    input logic             pending,
    input logic             start,
    input logic             grant,
    input logic [SUM_W-1:0] cnt,
    input logic [SUM_W-1:0] total
);
    // R2: busy medium in single-stage mode keeps the grant low
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (half && !two && (tx_act || rx_act) && !grant) |=> !grant);

    // R8: grant persists until the frame starts
    a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !start) |=> grant);

    // R8: frame start clears the grant
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !grant);

    // R10: nothing pending, no new grant
    a_r10_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && !pending) |=> !grant);

    // R7: full duplex with a completed count grants on the next edge
    a_r7_full_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        (!half && pending && !grant && !start && (cnt >= total)) |=> grant);
endmodule

bind hdx_defer_timer hdx_defer_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .half    (half_duplex_i),
    .two     (two_part_i),
    .tx_act  (tx_active_i),
    .rx_act  (rx_active_i),
    .pending (frame_pending_i),
    .start   (tx_start_i),
    .grant   (start_ok_o),
    .cnt     (cnt_q),
    .total   (total_w)
);

// File: tb/test_hdx_defer_timer.sv
module test_hdx_defer_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half = 1'b1, two = 1'b0, txa = 1'b0, rxa = 1'b0;
    logic       pend = 1'b0, start = 1'b0, cfg = 1'b0;
    logic [7:0] c1 = 8'd0, c2 = 8'd0;
    logic       grant;

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference state
    int m_cnt, m_p1, m_p2, m_tot;
    bit m_grant, m_busy, m_fin, m_may;

    always #10 clk = ~clk;  // 50 MHz

    hdx_defer_timer i_hdx_defer_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .half_duplex_i   (half),
        .two_part_i      (two),
        .tx_active_i     (txa),
        .rx_active_i     (rxa),
        .frame_pending_i (pend),
        .tx_start_i      (start),
        .cfg_load_i      (cfg),
        .cfg_part1_i     (c1),
        .cfg_part2_i     (c2),
        .start_ok_o      (grant)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_grant = 0; m_p1 = 64; m_p2 = 32;
        end else begin
            m_busy = half && (txa || rxa);
            m_tot  = m_p1 + m_p2;
            m_fin  = (m_cnt >= m_tot);
            m_may  = two ? ((m_cnt < m_p1) || (m_fin && !pend)) : 1'b1;
            if (start) begin
                m_cnt = 0; m_grant = 0;
            end else if (!m_grant) begin
                if (m_busy && m_may) m_cnt = 0;
                else begin
                    if (pend && m_fin) m_grant = 1;
                    if (!m_fin) m_cnt = m_cnt + 1;
                end
            end
            if (cfg) begin m_p1 = int'(c1); m_p2 = int'(c2); end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (grant !== m_grant) begin
                fails++;
                $display("FAIL %s model compare: actual=%b expected=%b", cur_req, grant, m_grant);
            end
        end
    end

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (grant !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart_count();
        start = 1'b1; wait_n(1); start = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        wait_n(3);
        cur_req = "R1";
        chk(1'b0, "R1 grant low in reset");
        rst_n = 1'b1;
        wait_n(1);
        chk(1'b0, "R1 grant low after reset");

        // R3 with R1 defaults: 96 total, grant on edge 97
        cur_req = "R3";
        pend = 1'b1;
        restart_count();
        wait_n(96); chk(1'b0, "R3/R1 no grant at edge 96");
        wait_n(1);  chk(1'b1, "R3/R1 grant at edge 97");

        // R8: held through activity, cleared by start
        cur_req = "R8";
        rxa = 1'b1; wait_n(20); chk(1'b1, "R8 grant held through activity");
        rxa = 1'b0;
        restart_count(); chk(1'b0, "R8 start clears grant");

        // R9: load 10 + 6
        cur_req = "R9";
        c1 = 8'd10; c2 = 8'd6; cfg = 1'b1; wait_n(1); cfg = 1'b0;
        restart_count();
        wait_n(16); chk(1'b0, "R9 no grant at edge 16");
        wait_n(1);  chk(1'b1, "R9 grant at edge 17 with new lengths");

        // R4: single-stage restart
        cur_req = "R4";
        restart_count();
        wait_n(10);
        rxa = 1'b1; wait_n(1); rxa = 1'b0;
        wait_n(16); chk(1'b0, "R4 count restarted, no grant");
        wait_n(1);  chk(1'b1, "R4 grant after full count from restart");

        // R2: long busy period
        cur_req = "R2";
        txa = 1'b1;
        restart_count();
        wait_n(300); chk(1'b0, "R2 busy medium blocks grant");
        txa = 1'b0;

        // R5: two-stage, activity in first stage
        cur_req = "R5";
        two = 1'b1;
        restart_count();
        wait_n(5);
        rxa = 1'b1; wait_n(1); rxa = 1'b0;
        wait_n(16); chk(1'b0, "R5 first stage restarted");
        wait_n(1);  chk(1'b1, "R5 grant after restart");

        // R6: two-stage, activity in second stage held through grant edge
        cur_req = "R6";
        restart_count();
        wait_n(12);
        txa = 1'b1;
        wait_n(4); chk(1'b0, "R6 no grant at edge 16");
        wait_n(1); chk(1'b1, "R6 grant at edge 17 despite activity");
        wait_n(5); chk(1'b1, "R8 grant still held while busy");
        txa = 1'b0;

        // R11: completed count, nothing pending, activity restarts
        cur_req = "R11";
        pend = 1'b0;
        restart_count();
        wait_n(20);
        rxa = 1'b1; wait_n(1); rxa = 1'b0;
        pend = 1'b1;
        wait_n(1);  chk(1'b0, "R11 idle count restarted by activity");
        wait_n(15); chk(1'b0, "R11 no grant at edge 16");
        wait_n(1);  chk(1'b1, "R11 grant at edge 17");

        // R7: full duplex ignores activity
        cur_req = "R7";
        two = 1'b0; half = 1'b0; txa = 1'b1; rxa = 1'b1;
        restart_count();
        wait_n(16); chk(1'b0, "R7 no grant at edge 16");
        wait_n(1);  chk(1'b1, "R7 grant despite activity");
        txa = 1'b0; rxa = 1'b0; half = 1'b1;

        // R10: no pending frame
        cur_req = "R10";
        pend = 1'b0;
        restart_count();
        wait_n(40); chk(1'b0, "R10 no grant without pending frame");
        pend = 1'b1;
        wait_n(1);  chk(1'b1, "R10 grant one edge after frame pending");
        restart_count();

        wait_n(2);
        finish_run();
    end
endmodule